// File: doc/BRIEF.md
# IP and TCP/UDP Header Exception Classifier

The classifier watches a packet that arrives as a byte stream, one byte per accepted cycle, starting with the first byte of the IP header. It decodes an IPv4 or IPv6 header and the TCP or UDP header behind it. It checks the header for structural faults and the transport header for suspicious contents. When the last byte has been taken, it presents a single status word for one cycle: classification flags, an IP-exception flag, an L4-error flag and one 8-bit anomaly code.

A receive pipeline uses it beside the packet buffer. The status word tells later stages whether the packet can go down the fast path. If it cannot, the code says why. Only the most important anomaly is reported, so each packet has exactly one code. IP-level faults take precedence over transport faults. Transport checks are skipped for fragments.

Top module: `hdr_exc_classifier`

## Requirements
- R1: A byte is accepted when `in_valid` is high and either `in_sop` is high (this restarts the packet at byte index 0) or a packet is open. Bytes with `in_valid` high and no open packet are ignored. `st_done` is high for exactly the one cycle after the accepted byte that carries `in_eop`. While `st_done` is low, every other output is 0.
- R2: The high nibble of byte 0 is the version. A version other than 4 or 6 sets `st_ip_exc` with code 1 and clears `st_is_v6`, `st_tcp_udp`, `st_frag` and `st_decrypt`.
- R3: For version 4 or 6, code 3 is reported when fewer bytes arrive than the header length, or when an IPv4 header length field (low nibble of byte 0) is below 5. The header length is IHL×4 bytes for IPv4 and 40 bytes for IPv6.
- R4: For IPv4, code 2 is reported when the ones'-complement sum of the header's big-endian 16-bit words, with end-around carry, is not 0xFFFF.
- R5: Code 4 is reported when the byte count is smaller than the IP length. The IP length is the total-length field (bytes 2–3) for IPv4, and 40 plus the payload-length field (bytes 4–5) for IPv6. An IPv4 total length below the header length also gives code 4. Extra trailing bytes are not an error.
- R6: A zero TTL (IPv4 byte 8) or a zero hop limit (IPv6 byte 7) gives code 5. An IPv4 header length field above 5 gives code 6.
- R7: The IP codes rank, from highest to lowest: 3, 1, 2, 4, 5, 6. Only the highest-ranked code is reported. When `st_ip_exc` is set, `st_l4_err` is 0.
- R8: `st_frag` is set for IPv4 when bit 5 of byte 6 (more fragments) is set or the 13-bit offset {byte6[4:0], byte7} is non-zero. It is set for IPv6 when the next-header byte 6 equals 44. Transport checks run only when there is no IP exception and no fragment.
- R9: The protocol is IPv4 byte 9 or IPv6 byte 6. `st_tcp_udp` is set for 6 or 17. `st_decrypt` is set for 50 or 51. `st_is_v6` is set for version 6.
- R10: Code 1 with `st_l4_err` is reported when the IP length minus the header length is below 20 bytes for TCP or below 8 bytes for UDP.
- R11: For UDP, code 3 is reported when the UDP length (transport bytes 4–5) exceeds the IP length minus the header length. For TCP or UDP, code 4 is reported when the source port (bytes 0–1) or destination port (bytes 2–3) is zero. L4 codes rank 1, 3, 4, then the TCP flag codes.
- R12: TCP flags are transport byte 13, with FIN bit 0, SYN bit 1, RST bit 2 and URG bit 5; bits 7:6 are ignored. The checks are applied in this order: FIN alone (bits 5:0 equal 000001) gives 8; no flags gives 9; FIN with RST gives 10; SYN with URG gives 11; SYN with RST gives 12; SYN with FIN gives 13.
- R13: A packet with no anomaly gives code 0 with both exception flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | Marks the first IP header byte |
| in_eop | input | 1 | Marks the last byte of the packet |
| in_byte | input | 8 | Packet byte |
| st_done | output | 1 | Status word valid, one cycle |
| st_is_v6 | output | 1 | Packet is IPv6 |
| st_tcp_udp | output | 1 | Protocol is TCP or UDP |
| st_frag | output | 1 | Packet is a fragment |
| st_decrypt | output | 1 | Protocol is ESP or AH |
| st_ip_exc | output | 1 | IP-level exception |
| st_l4_err | output | 1 | Transport-level error |
| st_code | output | 8 | Highest-ranked anomaly code |

## Verification
The status word of one packet can be on the outputs in the same cycle that the start byte of the next packet is accepted and clears the capture registers. The bench provokes this by sending packets back to back, with no idle cycle after an end byte. It then compares the first packet's status, sampled in that shared cycle, against the value computed from that packet's bytes alone. A second overlap is between the final header byte and the end marker, when they fall in the same cycle: a truncation sweep ends packets at every length from 1 to 40 bytes, so the last-byte contribution to the checksum, field capture and byte count must all be settled in the status cycle.

// File: rtl/hxc_pkg.sv
package hxc_pkg;
  localparam logic [7:0] CODE_NONE     = 8'd0;
  localparam logic [7:0] IPX_VERSION   = 8'd1;
  localparam logic [7:0] IPX_HDR_CSUM  = 8'd2;
  localparam logic [7:0] IPX_SHORT_HDR = 8'd3;
  localparam logic [7:0] IPX_SHORT_PKT = 8'd4;
  localparam logic [7:0] IPX_HOP_ZERO  = 8'd5;
  localparam logic [7:0] IPX_OPTIONS   = 8'd6;
  localparam logic [7:0] L4X_MALFORMED = 8'd1;
  localparam logic [7:0] L4X_UDP_LEN   = 8'd3;
  localparam logic [7:0] L4X_PORT_ZERO = 8'd4;
  localparam logic [7:0] L4X_FIN_ONLY  = 8'd8;
  localparam logic [7:0] L4X_NO_FLAGS  = 8'd9;
  localparam logic [7:0] L4X_FIN_RST   = 8'd10;
  localparam logic [7:0] L4X_SYN_URG   = 8'd11;
  localparam logic [7:0] L4X_SYN_RST   = 8'd12;
  localparam logic [7:0] L4X_SYN_FIN   = 8'd13;

  localparam logic [7:0] PROTO_TCP   = 8'd6;
  localparam logic [7:0] PROTO_UDP   = 8'd17;
  localparam logic [7:0] PROTO_FRAG6 = 8'd44;
  localparam logic [7:0] PROTO_ESP   = 8'd50;
  localparam logic [7:0] PROTO_AH    = 8'd51;

  localparam int V6_HDR_BYTES  = 40;
  localparam int TCP_MIN_BYTES = 20;
  localparam int UDP_MIN_BYTES = 8;
  localparam int TCP_FLAG_OFS  = 13;

  typedef struct packed {
    logic [7:0]  b0;
    logic [15:0] len4;
    logic [15:0] len6;
    logic [7:0]  b6;
    logic [7:0]  b7;
    logic [7:0]  b8;
    logic [7:0]  b9;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] ulen;
    logic [5:0]  tflags;
  } hxc_fields_t;

  // header length in bytes implied by the first header byte
  function automatic logic [7:0] hdr_bytes(input logic [7:0] first);
    if (first[7:4] == 4'd6) return 8'(V6_HDR_BYTES);
    return {2'b00, first[3:0], 2'b00};
  endfunction
endpackage

// File: rtl/hxc_byte_track.sv
module hxc_byte_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             acc,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] total,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    acc    = in_valid && (in_sop || open_q);
    idx    = in_sop ? '0 : cnt_q;
    open_d = acc ? !in_eop : open_q;
    cnt_d  = (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
    done_d = acc && in_eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (acc) begin
        open_q <= open_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign total = cnt_q;
  assign done  = done_q;
endmodule

// File: rtl/hxc_field_cap.sv
module hxc_field_cap
  import hxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sop,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  output hxc_fields_t      fld
);
  hxc_fields_t      fld_q, fld_d;
  logic [CNT_W-1:0] l4_ofs, rel;

  always_comb begin
    l4_ofs = CNT_W'(hdr_bytes(fld_q.b0));
    rel    = idx - l4_ofs;
    fld_d  = fld_q;
    if (sop) begin
      fld_d    = '0;
      fld_d.b0 = data;
    end else begin
      case (idx)
        CNT_W'(2): fld_d.len4[15:8] = data;
        CNT_W'(3): fld_d.len4[7:0]  = data;
        CNT_W'(4): fld_d.len6[15:8] = data;
        CNT_W'(5): fld_d.len6[7:0]  = data;
        CNT_W'(6): fld_d.b6         = data;
        CNT_W'(7): fld_d.b7         = data;
        CNT_W'(8): fld_d.b8         = data;
        CNT_W'(9): fld_d.b9         = data;
        default: ;
      endcase
      if (idx >= l4_ofs) begin
        case (rel)
          CNT_W'(0): fld_d.sport[15:8] = data;
          CNT_W'(1): fld_d.sport[7:0]  = data;
          CNT_W'(2): fld_d.dport[15:8] = data;
          CNT_W'(3): fld_d.dport[7:0]  = data;
          CNT_W'(4): fld_d.ulen[15:8]  = data;
          CNT_W'(5): fld_d.ulen[7:0]   = data;
          CNT_W'(TCP_FLAG_OFS): fld_d.tflags = data[5:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fld_q <= '0;
    else if (acc) fld_q <= fld_d;
  end

  assign fld = fld_q;
endmodule

// File: rtl/hxc_csum_acc.sv
module hxc_csum_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sop,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [7:0]       hdr_len,
  output logic [15:0]      sum
);
  logic [7:0]  hi_q, hi_d;
  logic [15:0] sum_q, sum_d;
  logic [16:0] wide;

  always_comb begin
    hi_d  = hi_q;
    sum_d = sum_q;
    wide  = {1'b0, sum_q} + {1'b0, hi_q, data};
    if (sop) begin
      hi_d  = data;
      sum_d = '0;
    end else if (idx < CNT_W'(hdr_len)) begin
      if (!idx[0]) hi_d  = data;
      else         sum_d = wide[15:0] + {15'd0, wide[16]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      sum_q <= '0;
    end else if (acc) begin
      hi_q  <= hi_d;
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;
endmodule

// File: rtl/hxc_resolve.sv
module hxc_resolve
  import hxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  hxc_fields_t      fld,
  input  logic [CNT_W-1:0] total,
  input  logic [15:0]      csum,
  output logic             is_v6,
  output logic             tcp_udp,
  output logic             frag,
  output logic             decrypt,
  output logic             ip_exc,
  output logic             l4_err,
  output logic [7:0]       code
);
  logic        is4, is6, known, tcp, udp, l4_on;
  logic [31:0] hl, tot, ip_len, avail;
  logic [7:0]  proto, hop, ip_code, l4_code;
  logic [5:0]  f;

  always_comb begin
    is4    = fld.b0[7:4] == 4'd4;
    is6    = fld.b0[7:4] == 4'd6;
    known  = is4 || is6;
    hl     = 32'(hdr_bytes(fld.b0));
    tot    = 32'(total);
    ip_len = is6 ? 32'(V6_HDR_BYTES) + 32'(fld.len6) : 32'(fld.len4);
    proto  = is6 ? fld.b6 : fld.b9;
    hop    = is6 ? fld.b7 : fld.b8;
    avail  = ip_len - hl;

    if (known && (tot < hl || (is4 && fld.b0[3:0] < 4'd5))) ip_code = IPX_SHORT_HDR;
    else if (!known)                                       ip_code = IPX_VERSION;
    else if (is4 && csum != 16'hFFFF)                      ip_code = IPX_HDR_CSUM;
    else if (tot < ip_len || (is4 && ip_len < hl))         ip_code = IPX_SHORT_PKT;
    else if (hop == 8'd0)                                  ip_code = IPX_HOP_ZERO;
    else if (is4 && fld.b0[3:0] > 4'd5)                    ip_code = IPX_OPTIONS;
    else                                                   ip_code = CODE_NONE;

    frag = is4 ? (fld.b6[5] || {fld.b6[4:0], fld.b7} != 13'd0)
               : (is6 && fld.b6 == PROTO_FRAG6);
    tcp  = known && proto == PROTO_TCP;
    udp  = known && proto == PROTO_UDP;
    f    = fld.tflags;

    if ((tcp && avail < 32'(TCP_MIN_BYTES)) || (udp && avail < 32'(UDP_MIN_BYTES)))
                                                 l4_code = L4X_MALFORMED;
    else if (udp && 32'(fld.ulen) > avail)       l4_code = L4X_UDP_LEN;
    else if (fld.sport == '0 || fld.dport == '0) l4_code = L4X_PORT_ZERO;
    else if (tcp && f == 6'b000001)              l4_code = L4X_FIN_ONLY;
    else if (tcp && f == 6'b000000)              l4_code = L4X_NO_FLAGS;
    else if (tcp && f[0] && f[2])                l4_code = L4X_FIN_RST;
    else if (tcp && f[1] && f[5])                l4_code = L4X_SYN_URG;
    else if (tcp && f[1] && f[2])                l4_code = L4X_SYN_RST;
    else if (tcp && f[1] && f[0])                l4_code = L4X_SYN_FIN;
    else                                         l4_code = CODE_NONE;

    l4_on   = (ip_code == CODE_NONE) && !frag && (tcp || udp);
    is_v6   = is6;
    tcp_udp = tcp || udp;
    frag    = known && frag;
    decrypt = known && (proto == PROTO_ESP || proto == PROTO_AH);
    ip_exc  = ip_code != CODE_NONE;
    l4_err  = l4_on && l4_code != CODE_NONE;
    code    = ip_exc ? ip_code : (l4_err ? l4_code : CODE_NONE);
  end
endmodule

// File: rtl/hdr_exc_classifier.sv
module hdr_exc_classifier
  import hxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_byte,
  output logic       st_done,
  output logic       st_is_v6,
  output logic       st_tcp_udp,
  output logic       st_frag,
  output logic       st_decrypt,
  output logic       st_ip_exc,
  output logic       st_l4_err,
  output logic [7:0] st_code
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             acc, done;
  logic [CNT_W-1:0] idx, total;
  hxc_fields_t      fld;
  logic [15:0]      csum;
  logic             r_v6, r_tu, r_frag, r_dec, r_ipx, r_l4;
  logic [7:0]       r_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  hxc_byte_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .acc(acc), .idx(idx), .total(total), .done(done));

  hxc_field_cap #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .acc(acc), .sop(in_sop), .idx(idx),
    .data(in_byte), .fld(fld));

  hxc_csum_acc #(.CNT_W(CNT_W)) u_csum (
    .clk(clk), .rst_n(rst_core_n), .acc(acc), .sop(in_sop), .idx(idx),
    .data(in_byte), .hdr_len(hdr_bytes(fld.b0)), .sum(csum));

  hxc_resolve #(.CNT_W(CNT_W)) u_res (
    .fld(fld), .total(total), .csum(csum), .is_v6(r_v6), .tcp_udp(r_tu),
    .frag(r_frag), .decrypt(r_dec), .ip_exc(r_ipx), .l4_err(r_l4), .code(r_code));

  always_comb begin
    st_done    = done;
    st_is_v6   = done && r_v6;
    st_tcp_udp = done && r_tu;
    st_frag    = done && r_frag;
    st_decrypt = done && r_dec;
    st_ip_exc  = done && r_ipx;
    st_l4_err  = done && r_l4;
    st_code    = done ? r_code : 8'd0;
  end
endmodule

// File: rtl/hxc_checker.sv
module hxc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_eop,
  input logic       st_done,
  input logic       st_is_v6,
  input logic       st_tcp_udp,
  input logic       st_frag,
  input logic       st_decrypt,
  input logic       st_ip_exc,
  input logic       st_l4_err,
  input logic [7:0] st_code
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_done |-> (st_code == 8'd0 && !st_is_v6 && !st_tcp_udp && !st_frag &&
                  !st_decrypt && !st_ip_exc && !st_l4_err));

  p_done_after_eop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> $past(in_valid && in_eop));

  p_single_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> !(st_ip_exc && st_l4_err));

  p_ip_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_ip_exc |-> (st_code >= 8'd1 && st_code <= 8'd6));

  p_frag_skips_l4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_frag |-> !st_l4_err);

  p_l4_code_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    st_l4_err |-> (st_code == 8'd1 || st_code == 8'd3 || st_code == 8'd4 ||
                   (st_code >= 8'd8 && st_code <= 8'd13)));

  p_clean_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> ((st_code != 8'd0) == (st_ip_exc || st_l4_err)));

  p_version_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ip_exc && st_code == 8'd1) |-> !(st_is_v6 || st_tcp_udp || st_frag || st_decrypt));
endmodule

bind hdr_exc_classifier hxc_checker i_hxc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .st_done(st_done), .st_is_v6(st_is_v6), .st_tcp_udp(st_tcp_udp),
  .st_frag(st_frag), .st_decrypt(st_decrypt), .st_ip_exc(st_ip_exc),
  .st_l4_err(st_l4_err), .st_code(st_code));

// File: tb/test_hdr_exc_classifier.sv
`timescale 1ns/1ps
module test_hdr_exc_classifier;
  logic clk, rst_n, in_valid, in_sop, in_eop;
  logic [7:0] in_byte;
  logic st_done, st_is_v6, st_tcp_udp, st_frag, st_decrypt, st_ip_exc, st_l4_err;
  logic [7:0] st_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] pkt [0:127];
  int n;
  bit pending = 0;
  string pend_tag;
  logic [13:0] pend_exp;

  hdr_exc_classifier i_hdr_exc_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_byte(in_byte), .st_done(st_done), .st_is_v6(st_is_v6),
    .st_tcp_udp(st_tcp_udp), .st_frag(st_frag), .st_decrypt(st_decrypt),
    .st_ip_exc(st_ip_exc), .st_l4_err(st_l4_err), .st_code(st_code));

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int get(int i);
    return (i >= 0 && i < n) ? int'(pkt[i]) : 0;
  endfunction

  // expected status {v6,tu,frag,dec,ipx,l4,code}, from the requirements
  function automatic logic [13:0] model();
    int v = get(0) >> 4, ihl = get(0) & 15, hl, ipl, s, ttl, proto, avail, b, fl;
    bit is4 = (v == 4), is6 = (v == 6), known, frag, tcp, udp, dec;
    int ipc = 0, l4c = 0;
    known = is4 || is6;
    hl  = is6 ? 40 : ihl * 4;
    ipl = is6 ? 40 + get(4) * 256 + get(5) : get(2) * 256 + get(3);
    s = 0;
    for (int i = 0; i < hl; i += 2) s += get(i) * 256 + get(i + 1);
    while (s > 65535) s = (s & 65535) + (s >> 16);
    ttl   = is6 ? get(7) : get(8);
    proto = is6 ? get(6) : get(9);
    if (known && (n < hl || (is4 && ihl < 5))) ipc = 3;       // R3
    else if (!known) ipc = 1;                                 // R2
    else if (is4 && s != 65535) ipc = 2;                      // R4
    else if (n < ipl || (is4 && ipl < hl)) ipc = 4;           // R5
    else if (ttl == 0) ipc = 5;                               // R6
    else if (is4 && ihl > 5) ipc = 6;
    frag = known && (is4 ? ((get(6) & 8'h20) != 0 || ((get(6) & 31) * 256 + get(7)) != 0)
                         : proto == 44);
    tcp = known && proto == 6;
    udp = known && proto == 17;
    dec = known && (proto == 50 || proto == 51);
    if (ipc == 0 && !frag && (tcp || udp)) begin
      avail = ipl - hl; b = hl; fl = get(b + 13) & 63;
      if ((tcp && avail < 20) || (udp && avail < 8)) l4c = 1;          // R10
      else if (udp && get(b + 4) * 256 + get(b + 5) > avail) l4c = 3;   // R11
      else if (get(b) * 256 + get(b + 1) == 0 || get(b + 2) * 256 + get(b + 3) == 0) l4c = 4;
      else if (tcp && fl == 1) l4c = 8;                                 // R12
      else if (tcp && fl == 0) l4c = 9;
      else if (tcp && (fl & 5) == 5) l4c = 10;
      else if (tcp && (fl & 34) == 34) l4c = 11;
      else if (tcp && (fl & 6) == 6) l4c = 12;
      else if (tcp && (fl & 3) == 3) l4c = 13;
    end
    return {is6, tcp || udp, frag, dec, ipc != 0, l4c != 0,
            8'(ipc != 0 ? ipc : l4c)};
  endfunction

  task automatic check_vec(input string tag, input logic [13:0] exp);
    logic [13:0] act = {st_is_v6, st_tcp_udp, st_frag, st_decrypt, st_ip_exc, st_l4_err, st_code};
    checks++;
    if (!st_done || act !== exp) begin
      errors++;
      $display("FAIL %s: done=%0b status=%h expected done=1 status=%h", tag, st_done, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (st_done !== 1'b0 || st_code !== 8'd0) begin
      errors++;
      $display("FAIL %s: done=%0b code=%0d expected done=0 code=0", tag, st_done, st_code);
    end
  endtask

  task automatic drive_pkt(input string tag, input int gap);
    logic [13:0] e = model();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0 && pending) check_vec(pend_tag, pend_exp);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == n - 1); in_byte = pkt[i];
      if (gap > 0 && i == n / 2) begin
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; in_byte = 8'hA5;
        repeat (gap - 1) @(negedge clk);
      end
    end
    pending = 1; pend_tag = tag; pend_exp = e;
  endtask

  task automatic finish_pkt();
    @(negedge clk);
    check_vec(pend_tag, pend_exp);
    pending = 0; in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic run(input string tag);
    drive_pkt(tag, 0);
    finish_pkt();
  endtask

  task automatic fix_csum();
    int hl = (pkt[0] & 15) * 4, s = 0;
    pkt[10] = 0; pkt[11] = 0;
    for (int i = 0; i < hl; i += 2) s += pkt[i] * 256 + pkt[i + 1];
    while (s > 65535) s = (s & 65535) + (s >> 16);
    s = (~s) & 65535;
    pkt[10] = 8'(s >> 8); pkt[11] = 8'(s & 255);
  endtask

  task automatic mk_v4(input int ihl, input int pay, input int proto);
    for (int i = 0; i < 128; i++) pkt[i] = 8'(i * 7 + 3);
    n = ihl * 4 + pay;
    pkt[0] = 8'(8'h40 | ihl); pkt[1] = 0;
    pkt[2] = 8'(n >> 8); pkt[3] = 8'(n & 255);
    pkt[6] = 0; pkt[7] = 0; pkt[8] = 64; pkt[9] = 8'(proto);
    fix_csum();
  endtask

  task automatic mk_v6(input int pay, input int nh);
    for (int i = 0; i < 128; i++) pkt[i] = 8'(i * 5 + 1);
    n = 40 + pay;
    pkt[0] = 8'h60; pkt[4] = 8'(pay >> 8); pkt[5] = 8'(pay & 255);
    pkt[6] = 8'(nh); pkt[7] = 32;
  endtask

  task automatic put_tcp(input int o, input int sp, input int dp, input int fl);
    pkt[o] = 8'(sp >> 8); pkt[o+1] = 8'(sp & 255);
    pkt[o+2] = 8'(dp >> 8); pkt[o+3] = 8'(dp & 255);
    pkt[o+12] = 8'h50; pkt[o+13] = 8'(fl);
  endtask

  task automatic put_udp(input int o, input int sp, input int dp, input int ul);
    pkt[o] = 8'(sp >> 8); pkt[o+1] = 8'(sp & 255);
    pkt[o+2] = 8'(dp >> 8); pkt[o+3] = 8'(dp & 255);
    pkt[o+4] = 8'(ul >> 8); pkt[o+5] = 8'(ul & 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle("R1 reset state");

    // R13 clean packets, R9 classification
    mk_v4(5, 24, 6); put_tcp(20, 1234, 80, 8'h10); run("R13 clean v4 tcp");
    mk_v4(5, 12, 17); put_udp(20, 53, 999, 12); run("R9 R13 clean v4 udp");
    mk_v6(20, 6); put_tcp(40, 7, 8, 8'h18); run("R9 clean v6 tcp");
    mk_v4(5, 10, 50); run("R9 esp decrypt");
    mk_v6(10, 51); run("R9 v6 ah decrypt");

    // R12 exhaustive flag sweep, ECN bits 7:6 set on odd values
    for (int f = 0; f < 64; f++) begin
      mk_v4(5, 20, 6); put_tcp(20, 4000, 443, (f & 1) ? (f | 8'hC0) : f);
      run("R12 tcp flag sweep");
    end

    // R2 version nibble sweep
    for (int v = 0; v < 16; v++) begin
      mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10);
      pkt[0] = 8'((v << 4) | 5); fix_csum();
      run("R2 version sweep");
    end

    // R3 R5 truncation sweep, 1..40 bytes
    for (int k = 1; k <= 40; k++) begin
      mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); n = k;
      run("R3 R5 truncation sweep");
    end

    mk_v4(3, 30, 6); run("R3 ihl below five");
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); pkt[11] = pkt[11] ^ 8'h01; run("R4 bad checksum");
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); pkt[8] = 0; fix_csum(); pkt[11] = pkt[11] ^ 8'h40;
    run("R7 checksum over ttl");
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); pkt[8] = 0; fix_csum(); run("R6 ttl zero");
    mk_v6(20, 6); put_tcp(40, 1, 2, 8'h10); pkt[7] = 0; run("R6 hop limit zero");
    mk_v4(6, 20, 6); put_tcp(24, 1, 2, 8'h10); run("R6 options");
    mk_v4(6, 20, 6); put_tcp(24, 1, 2, 8'h10); pkt[8] = 0; fix_csum(); run("R7 ttl over options");
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); n = 45; run("R5 pad allowed");
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h10); pkt[2] = 0; pkt[3] = 12; fix_csum(); run("R5 total below header");
    mk_v6(30, 17); put_udp(40, 1, 2, 8); n = 50; run("R5 v6 short payload");

    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 0); pkt[6] = 8'h20; fix_csum(); run("R8 more fragments");
    mk_v4(5, 20, 6); put_tcp(20, 0, 2, 1); pkt[7] = 8'h08; fix_csum(); run("R8 fragment offset");
    mk_v6(20, 44); run("R8 v6 fragment header");

    mk_v4(5, 20, 17); put_udp(20, 1, 2, 21); run("R11 udp length overrun");
    mk_v4(5, 20, 17); put_udp(20, 0, 2, 8); run("R11 udp zero port");
    mk_v4(5, 20, 6); put_tcp(20, 9, 0, 8'h03); run("R11 tcp zero port over flags");
    mk_v4(5, 6, 17); put_udp(20, 1, 2, 6); run("R10 udp malformed");
    mk_v4(5, 19, 6); put_tcp(20, 1, 2, 8'h10); run("R10 tcp malformed");

    // R1 gaps inside a packet, stray byte outside, back-to-back packets
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h01); drive_pkt("R1 valid gaps", 3); finish_pkt();
    @(negedge clk); in_valid = 1; in_sop = 0; in_eop = 1; in_byte = 8'h45;
    @(negedge clk); check_idle("R1 stray byte ignored"); in_valid = 0; in_eop = 0;
    mk_v4(5, 20, 6); put_tcp(20, 1, 2, 8'h06); drive_pkt("R1 back-to-back first", 0);
    mk_v6(8, 17); put_udp(40, 5, 6, 8); drive_pkt("R1 back-to-back second", 0);
    mk_v4(5, 0, 1); n = 1; drive_pkt("R1 one-byte packet", 0);
    finish_pkt();
    @(negedge clk); check_idle("R1 done single cycle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule